// File: doc/BRIEF.md
# I2C Pointer-Addressed Readback Target

This block is an I2C target that lets a bus controller read back the state of two measurement counters and two status flags. It runs entirely on the system clock. It oversamples the SCL and SDA lines through synchronizers and pulls SDA low through an open-drain enable. The counter words and flags arrive as plain inputs. The logic that produces them lies outside this block.

A controller first writes one byte to the target. That byte becomes the register pointer. The controller then issues a repeated START, or a fresh transaction, and reads. The target returns the byte that the pointer selects. When the top pointer bit is set, the pointer selects a status byte. Otherwise its three low bits pick one of eight counter bytes, with the least significant byte first. The selected byte is frozen in a transmit register at the moment the read address is acknowledged. Counters that keep running during the transfer therefore cannot tear the byte on the wire.

Top module: `i2c_ptr_target`

## Requirements
- R1: The target acknowledges a byte holding the 7-bit address 0x21, sent MSB first, followed by a direction bit (0 = write, 1 = read). It acknowledges by pulling SDA low during the ninth SCL clock.
- R2: The target answers any other address with no acknowledge. It then leaves SDA released and the pointer unchanged until the next START.
- R3: Every data byte written after a matching write address is acknowledged in its ninth clock. It is stored as the pointer and appears on `ptr_o`.
- R4: When pointer bit 7 is 1, a read returns the status byte {6'b000000, underflow_i, ready_i}, with ready_i in bit 0.
- R5: When pointer bit 7 is 0, pointer bits 2:0 pick the byte to read. Values 0 to 3 return cnt_a_i bytes 0 to 3, least significant first. Values 4 to 7 return cnt_b_i bytes 0 to 3 in the same order. Pointer bits 6:3 are ignored.
- R6: Read data goes out MSB first. SDA changes only while SCL is low and stays constant while SCL is high. After the eighth bit the target releases SDA for the controller's acknowledge.
- R7: The read byte is captured when the read address is acknowledged. Counter changes after that point do not alter the byte being shifted out.
- R8: A STOP, or a START at any point, aborts a partly received byte without changing the pointer. A repeated START after the pointer write starts a new transaction.
- R9: After reset, SDA is released and the pointer is 0, so a read with no prior write returns cnt_a_i byte 0.
- R10: When the controller acknowledges a read byte, the target captures the currently selected byte again and sends it. When the controller does not acknowledge, the target releases the bus and waits for a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired bus level) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cnt_a_i | input | CNT_W | First measurement counter |
| cnt_b_i | input | CNT_W | Second measurement counter |
| ready_i | input | 1 | Ready flag, status bit 0 |
| underflow_i | input | 1 | Underflow flag, status bit 1 |
| ptr_o | output | 8 | Current register pointer |

## Verification
Two conditions are hard to reach from the ports. The first is a counter that moves while its byte is already on the wire. The bench produces it by changing the counter inputs after the read address is acknowledged and before the data clocks start. It expects the old byte, and after a controller acknowledge it expects the new byte. The second is an abort in the middle of a byte. A STOP and a repeated START are placed after a few data bits, and the bench then checks that the pointer still holds its old value and that the next full transaction is served normally. The selection is swept over every pointer index, several pointers with ignored middle bits, all flag combinations and a set of near-miss addresses.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  // R8: a START and a STOP can never be seen in the same cycle
  assert_start_stop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
  // R6: bus conditions are only recognised while SCL stays high
  assert_cond_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> (scl_s && !scl_rise));
endmodule

// File: rtl/i2c_byte_sel.sv
module i2c_byte_sel #(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 2,
  localparam int BYTES_PER = CNT_W / i2c_ptr_pkg::BYTE_W,
  localparam int TOTAL     = NUM_CNT * BYTES_PER,
  localparam int IDX_W     = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic [NUM_CNT*CNT_W-1:0]      cnt_flat,
  input  logic                          flag_ready,
  input  logic                          flag_under,
  input  logic                          sel_status,
  input  logic [IDX_W-1:0]              sel_idx,
  output logic [i2c_ptr_pkg::BYTE_W-1:0] byte_o
);
  localparam int BW = i2c_ptr_pkg::BYTE_W;

  logic [BW-1:0] lane [TOTAL];

  genvar g;
  generate
    for (g = 0; g < TOTAL; g++) begin : g_lane
      assign lane[g] = cnt_flat[g*BW +: BW];
    end
  endgenerate

  logic [BW-1:0] status_byte;
  assign status_byte = {{(BW-2){1'b0}}, flag_under, flag_ready};

  always_comb begin
    if (sel_status) begin
      byte_o = status_byte;
    end else if (int'(sel_idx) < TOTAL) begin
      byte_o = lane[sel_idx];
    end else begin
      byte_o = '0;
    end
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_ptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr
);
  tgt_state_e        state_q, state_d;
  logic [3:0]        bit_cnt_q, bit_cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              nack_q, nack_d;

  logic byte_full;
  assign byte_full = (bit_cnt_q == 4'd8);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    shift_d   = shift_q;
    tx_d      = tx_q;
    ptr_d     = ptr_q;
    oe_d      = oe_q;
    nack_d    = nack_q;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d   = ST_ADDR;
      bit_cnt_d = '0;
      oe_d      = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_WR_DATA: begin
          if (scl_rise && !byte_full) begin
            shift_d   = {shift_q[BYTE_W-2:0], sda_s};
            bit_cnt_d = bit_cnt_q + 4'd1;
          end else if (scl_fall && byte_full) begin
            if (state_q == ST_WR_DATA) begin
              ptr_d   = shift_q;
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
            end else if (shift_q[7:1] == DEV_ADDR) begin
              oe_d    = 1'b1;
              state_d = ST_ADDR_ACK;
              if (shift_q[0]) tx_d = rd_byte;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt_d = '0;
            if (shift_q[0]) begin
              state_d = ST_RD_DATA;
              oe_d    = ~tx_q[7];
            end else begin
              state_d = ST_WR_DATA;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d      = 1'b0;
            bit_cnt_d = '0;
            state_d   = ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (scl_rise && !byte_full) begin
            bit_cnt_d = bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (byte_full) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else if (bit_cnt_q != 4'd0) begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (!nack_q) begin
              tx_d      = rd_byte;
              oe_d      = ~rd_byte[7];
              bit_cnt_d = '0;
              state_d   = ST_RD_DATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      nack_q    <= 1'b1;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      shift_q   <= shift_d;
      tx_q      <= tx_d;
      ptr_q     <= ptr_d;
      oe_q      <= oe_d;
      nack_q    <= nack_d;
    end
  end

  assign sda_oe = oe_q;
  assign ptr    = ptr_q;

  // R8: any START enters address reception
  assert_start_to_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR && !sda_oe));
  // R8: any STOP returns to idle with the line released
  assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !sda_oe));
  // R2: SDA is pulled only in acknowledge or read-data phases
  assert_oe_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state_q == ST_ADDR_ACK || state_q == ST_WR_ACK || state_q == ST_RD_DATA));
  // R6: the target starts pulling SDA only while SCL is low
  assert_oe_rise_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R3: the pointer moves only at the end of a written data byte
  assert_ptr_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> $past(state_q) == ST_WR_DATA);
  // R7: the transmit byte holds between SCL falls while shifting out
  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_DATA && !scl_fall) |=> $stable(tx_q));
  // R6: the bit counter never passes a full byte
  assert_bitcnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= 4'd8);
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h21,
  parameter int         CNT_W       = 32,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  input  logic             ready_i,
  input  logic             underflow_i,
  output logic [7:0]       ptr_o
);
  localparam int NUM_CNT = 2;
  localparam int TOTAL   = NUM_CNT * (CNT_W / 8);
  localparam int IDX_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_byte;
  logic [7:0] ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_byte_sel #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_sel (
    .cnt_flat   ({cnt_b_i, cnt_a_i}),
    .flag_ready (ready_i),
    .flag_under (underflow_i),
    .sel_status (ptr[7]),
    .sel_idx    (ptr[IDX_W-1:0]),
    .byte_o     (rd_byte)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe_o),
    .ptr       (ptr)
  );

  assign ptr_o = ptr;

  // R9: while reset is held, SDA stays released
  assert_reset_release_R9: assert property (@(posedge clk)
    !rst_sync_n |-> !sda_oe_o);
endmodule

// File: tb/sim_i2c_ptr_target.sv
module sim_i2c_ptr_target;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;
  localparam logic [6:0] DEV = 7'h21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [31:0] cnt_a = '0;
  logic [31:0] cnt_b = '0;
  logic        rdy = 1'b0;
  logic        unf = 1'b0;
  wire         sda_oe;
  wire  [7:0]  ptr;
  wire         sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  int glitches = 0;
  int oe_cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (sda_oe) oe_cycles <= oe_cycles + 1;

  i2c_ptr_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .cnt_a_i(cnt_a), .cnt_b_i(cnt_b), .ready_i(rdy), .underflow_i(unf), .ptr_o(ptr)
  );

  task automatic qwait(); repeat (QTR) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] p, input logic [31:0] a,
                                          input logic [31:0] b, input logic r, input logic u);
    logic [31:0] w;
    if (p[7]) return {6'b0, u, r};
    w = p[2] ? b : a;
    return w[8*p[1:0] +: 8];
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask
  task automatic send_bit(input logic b, output logic seen);
    sda_m = b; qwait(); scl = 1'b1; qwait(); seen = sda_bus; qwait(); scl = 1'b0; qwait();
  endtask
  task automatic recv_bit(output logic b);
    logic s2;
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait(); b = sda_bus; qwait(); s2 = sda_bus;
    if (s2 !== b) glitches++;
    scl = 1'b0; qwait();
  endtask
  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(d[i], s);
    recv_bit(s);
    ack = (s == 1'b0);
  endtask
  task automatic recv_byte(input bit mack, output logic [7:0] d, output logic released);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(!mack, released);
  endtask

  // pointer write, repeated START, read one byte with NACK, STOP
  task automatic ptr_read(input logic [7:0] p, input string req);
    bit a1, a2, a3;
    logic [7:0] d;
    logic rel;
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    send_byte(p, a2);
    chk("R1 write address ack", 32'(a1), 32'd1);
    chk("R3 data ack", 32'(a2), 32'd1);
    chk("R3 ptr_o", 32'(ptr), 32'(p));
    bus_start();
    send_byte({DEV, 1'b1}, a3);
    chk("R1 read address ack after repeated START R8", 32'(a3), 32'd1);
    recv_byte(1'b0, d, rel);
    chk(req, 32'(d), 32'(exp_byte(p, cnt_a, cnt_b, rdy, unf)));
    chk("R6 SDA released for controller ack", 32'(rel), 32'd1);
    bus_stop();
  endtask

  initial begin
    logic [7:0] d;
    logic rel;
    bit a1, a2;
    int oe_before;
    logic [7:0] sweep [4];
    logic [6:0] bad [6];
    sweep[0] = 8'h08; sweep[1] = 8'h7D; sweep[2] = 8'hFF; sweep[3] = 8'hC3;
    bad[0] = 7'h20; bad[1] = 7'h22; bad[2] = 7'h61; bad[3] = 7'h01;
    bad[4] = 7'h7F; bad[5] = 7'h00;

    cnt_a = 32'hA1B2C3D4; cnt_b = 32'h5566E7F8;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9: reset state
    chk("R9 ptr after reset", 32'(ptr), 32'd0);
    chk("R9 SDA released after reset", 32'(sda_oe), 32'd0);
    bus_start();
    send_byte({DEV, 1'b1}, a1);
    chk("R1 read address ack", 32'(a1), 32'd1);
    recv_byte(1'b0, d, rel);
    chk("R9 default pointer reads cnt_a byte 0", 32'(d), 32'hD4);
    bus_stop();

    // R5: every counter index, fresh counter values each pass
    for (int i = 0; i < 8; i++) begin
      cnt_a = 32'h01020304 * (i + 3) + 32'h9E;
      cnt_b = 32'hF0E0D0C1 ^ (32'h11111111 * i);
      ptr_read(8'(i), "R5 counter byte select");
    end
    // R5/R4: middle pointer bits ignored, bit 7 selects status
    for (int i = 0; i < 4; i++) begin
      rdy = i[0]; unf = i[1];
      ptr_read(sweep[i], sweep[i][7] ? "R4 status byte" : "R5 ignored pointer bits");
    end
    // R4: all flag combinations through the status byte
    for (int i = 0; i < 4; i++) begin
      rdy = i[1]; unf = i[0];
      ptr_read(8'h80, "R4 status flags");
    end

    // R2: near-miss addresses are ignored
    for (int i = 0; i < 6; i++) begin
      oe_before = oe_cycles;
      bus_start();
      send_byte({bad[i], 1'b0}, a1);
      send_byte(8'h05, a2);
      bus_stop();
      chk("R2 no ack on foreign address", 32'(a1), 32'd0);
      chk("R2 no ack on following byte", 32'(a2), 32'd0);
      chk("R2 SDA never pulled", 32'(oe_cycles - oe_before), 32'd0);
      chk("R2 pointer unchanged", 32'(ptr), 32'h80);
    end

    // R7 and R10: counter moves after read address ack
    cnt_a = 32'h00001100;
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    send_byte(8'h01, a2);
    bus_start();
    send_byte({DEV, 1'b1}, a1);
    cnt_a = 32'h00007700;
    recv_byte(1'b1, d, rel);
    chk("R7 byte captured at address ack", 32'(d), 32'h11);
    recv_byte(1'b0, d, rel);
    chk("R10 acked read resends fresh selection", 32'(d), 32'h77);
    chk("R10 released after controller NACK", 32'(rel), 32'd1);
    bus_stop();
    chk("R10 SDA idle after NACK and STOP", 32'(sda_oe), 32'd0);

    // R8: STOP in the middle of a data byte
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b1, rel);
    bus_stop();
    chk("R8 STOP mid-byte keeps pointer", 32'(ptr), 32'h01);
    // R8: repeated START in the middle of a data byte
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    for (int i = 0; i < 3; i++) send_bit(1'b1, rel);
    cnt_b = 32'h3C000000;
    ptr_read(8'h07, "R8 transaction after mid-byte START");
    chk("R8 pointer after recovery", 32'(ptr), 32'h07);

    chk("R6 SDA stable while SCL high", 32'(glitches), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule